// File: doc/BRIEF.md
# Fully Associative Translation Micro-Cache

This block keeps a handful of recently used address translations in flip-flops, in front of a larger set-associative main translation buffer. A requester presents a virtual page number with an address-space identifier. In the same cycle the block answers with a hit flag, the physical frame number and the permission bits of the matching entry. Any entry can hold any page. The block therefore hides the small associativity of the main buffer, which would otherwise thrash when three or more hot pages land in the same set.

On a miss the block latches the requested page and identifier and raises a refill request toward the main buffer. It stalls further lookups until the response arrives, then installs the response. The entry goes into a free slot if there is one, and otherwise replaces the least recently used slot, tracked by per-entry age counters. An entry is removed only by replacement here or by the flush input. The main buffer drives flush when a page leaves the page table, through an ordinary write or an explicit invalidate. A main-buffer write that does not invalidate, and an eviction in the main buffer, leave the entries untouched. The entry count is a parameter: 8 for the data side, 4 for the instruction side.

Top module: `utlb_cache`

## Requirements
- R1: After reset no entry is valid: `lk_ready` is 1, `miss_req` is 0, and every lookup returns `lk_hit` 0.
- R2: A lookup with `lk_valid` 1 hits in the same cycle when a valid entry has an equal virtual page number and an equal identifier. `lk_pfn` and `lk_perm` then carry that entry's frame and permission bits.
- R3: An entry installed with `fill_global` 1 hits for its page under any identifier.
- R4: A non-global entry does not hit for a different identifier. Entries for the same page under different identifiers coexist.
- R5: A lookup accepted while `lk_ready` is 1 that misses, with no flush in that cycle, raises `miss_req` from the next cycle. `miss_vpn` and `miss_asid` then show the missed page and identifier, held stable until a fill or flush.
- R6: While a miss is outstanding, `lk_ready` is 0 and `lk_hit` is 0 for any lookup.
- R7: A `fill_valid` pulse with a miss outstanding installs the entry for the missed page and identifier. From the next cycle `miss_req` is 0, `lk_ready` is 1, and the same lookup hits.
- R8: Fills use free entries first, so ENTRIES fills of distinct pages after a flush all remain hittable.
- R9: When every entry is valid, a fill replaces the least recently used entry. Both hits and fills count as use, and all other entries keep hitting.
- R10: A one-cycle `flush` pulse invalidates every entry. Nothing hits from the next cycle.
- R11: When `flush` and `fill_valid` are 1 in the same cycle, the fill is discarded and the outstanding miss is cleared. The missed page does not hit afterwards.
- R12: A `fill_valid` pulse with no miss outstanding is ignored: no entry is installed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_ready | output | 1 | Block can accept a lookup (no miss outstanding) |
| lk_hit | output | 1 | Lookup matched an entry this cycle |
| lk_pfn | output | 20 | Physical frame of the matching entry, 0 otherwise |
| lk_perm | output | 6 | Permission bits of the matching entry, 0 otherwise |
| miss_req | output | 1 | Refill request to the main buffer |
| miss_vpn | output | 20 | Page number being refilled |
| miss_asid | output | 8 | Identifier being refilled |
| fill_valid | input | 1 | Refill response strobe |
| fill_global | input | 1 | Response entry ignores the identifier |
| fill_pfn | input | 20 | Response physical frame |
| fill_perm | input | 6 | Response permission bits |
| flush | input | 1 | Invalidate all entries |

## Verification
Every cycle, the checker confirms that no hit appears while a miss is outstanding and that a missing lookup raises the refill request. It also confirms that the request and its page and identifier stay steady until a response or flush, that a response drops the request, and that a flush empties the valid vector even when a fill arrives with it. Only the bench scenarios show which frame and permissions come back, that global entries ignore the identifier, and which entry is chosen for replacement. The bench checks replacement by filling every slot, touching the oldest, and confirming that the next oldest is the one that goes. It also shows that a discarded or unsolicited fill leaves no trace.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;
    localparam int PERM_W = 6;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } utlb_entry_t;

    function automatic logic entry_matches(input utlb_entry_t e,
                                           input logic [VPN_W-1:0] vpn,
                                           input logic [ASID_W-1:0] asid);
        return e.valid && (e.vpn == vpn) && (e.glob || (e.asid == asid));
    endfunction

    function automatic utlb_entry_t make_entry(input logic [VPN_W-1:0] vpn,
                                               input logic [ASID_W-1:0] asid,
                                               input logic glob,
                                               input logic [PFN_W-1:0] pfn,
                                               input logic [PERM_W-1:0] perm);
        utlb_entry_t e;
        e.valid = 1'b1;
        e.glob  = glob;
        e.vpn   = vpn;
        e.asid  = asid;
        e.pfn   = pfn;
        e.perm  = perm;
        return e;
    endfunction

endpackage

// File: rtl/utlb_store.sv
module utlb_store
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              flush,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  utlb_entry_t                       wr_entry,
    output utlb_entry_t [ENTRIES-1:0]         entries_o,
    output logic [ENTRIES-1:0]                valid_o
);

    utlb_entry_t [ENTRIES-1:0] ent_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_q <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_entry;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_o[g] = ent_q[g].valid;
    end

    assign entries_o = ent_q;

endmodule

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  utlb_entry_t [ENTRIES-1:0] entries_i,
    input  logic [VPN_W-1:0]          vpn_i,
    input  logic [ASID_W-1:0]         asid_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          hit_idx_o
);

    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = entry_matches(entries_i[g], vpn_i, asid_i);
    end

    // lowest index wins if several entries match
    always_comb begin
        hit_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx_o = IDX_W'(i);
            end
        end
    end

    assign hit_o = |match_vec;

endmodule

// File: rtl/utlb_lru.sv
module utlb_lru #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_i,
    output logic [IDX_W-1:0]   victim_o
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // ages form a permutation of 0..ENTRIES-1; 0 is most recent
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;
    logic             free_found;

    assign touched_age = age_q[touch_idx];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (touch_idx == IDX_W'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_o   = '0;
        free_found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                victim_o   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == OLDEST) begin
                    victim_o = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              miss_req,
    output logic [VPN_W-1:0]  miss_vpn,
    output logic [ASID_W-1:0] miss_asid,
    input  logic              fill_valid,
    input  logic              fill_global,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush
);

    utlb_entry_t [ENTRIES-1:0] entries;
    logic [ENTRIES-1:0]        valid_vec;
    logic                      any_match;
    logic [IDX_W-1:0]          match_idx;
    logic [IDX_W-1:0]          victim_idx;
    logic                      pending_q;
    logic [VPN_W-1:0]          req_vpn_q;
    logic [ASID_W-1:0]         req_asid_q;
    logic                      fill_take;
    logic                      miss_now;
    logic                      touch_en;
    logic [IDX_W-1:0]          touch_idx;
    utlb_entry_t               new_entry;

    assign lk_ready  = !pending_q;
    assign lk_hit    = lk_valid && !pending_q && any_match;
    assign miss_now  = lk_valid && !pending_q && !any_match;
    assign fill_take = fill_valid && pending_q && !flush;

    assign lk_pfn  = lk_hit ? entries[match_idx].pfn  : '0;
    assign lk_perm = lk_hit ? entries[match_idx].perm : '0;

    assign miss_req  = pending_q;
    assign miss_vpn  = req_vpn_q;
    assign miss_asid = req_asid_q;

    assign new_entry = make_entry(req_vpn_q, req_asid_q, fill_global, fill_pfn, fill_perm);
    assign touch_en  = fill_take || (lk_hit && !flush);
    assign touch_idx = fill_take ? victim_idx : match_idx;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pending_q <= 1'b0;
        end else if (fill_take) begin
            pending_q <= 1'b0;
        end else if (miss_now) begin
            pending_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_vpn_q  <= '0;
            req_asid_q <= '0;
        end else if (miss_now && !flush) begin
            req_vpn_q  <= lk_vpn;
            req_asid_q <= lk_asid;
        end
    end

    utlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (fill_take),
        .wr_idx   (victim_idx),
        .wr_entry (new_entry),
        .entries_o(entries),
        .valid_o  (valid_vec)
    );

    utlb_match #(.ENTRIES(ENTRIES)) u_match (
        .entries_i(entries),
        .vpn_i    (lk_vpn),
        .asid_i   (lk_asid),
        .hit_o    (any_match),
        .hit_idx_o(match_idx)
    );

    utlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .touch_en (touch_en),
        .touch_idx(touch_idx),
        .valid_i  (valid_vec),
        .victim_o (victim_idx)
    );

endmodule

// File: rtl/utlb_cache_chk.sv
module utlb_cache_chk
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic               lk_hit,
    input logic               miss_req,
    input logic [VPN_W-1:0]   miss_vpn,
    input logic [ASID_W-1:0]  miss_asid,
    input logic               fill_valid,
    input logic               flush,
    input logic [ENTRIES-1:0] valid_vec
);

    AST_STALL_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !lk_ready |-> !lk_hit); // R6

    AST_MISS_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && !lk_hit && !flush) |=> miss_req); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (miss_req && !fill_valid && !flush) |=>
            (miss_req && $stable(miss_vpn) && $stable(miss_asid))); // R5

    AST_FILL_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (miss_req && fill_valid) |=> !miss_req); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)); // R10

    AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (rst)
        (flush && fill_valid) |=> (valid_vec == '0 && !miss_req)); // R11

    AST_IDLE_FILL_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (!miss_req && fill_valid && !flush) |=>
            ($countones(valid_vec) == $countones($past(valid_vec)))); // R12

endmodule

bind utlb_cache utlb_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_hit    (lk_hit),
    .miss_req  (miss_req),
    .miss_vpn  (miss_vpn),
    .miss_asid (miss_asid),
    .fill_valid(fill_valid),
    .flush     (flush),
    .valid_vec (valid_vec)
);

// File: tb/test_utlb_cache.sv
module test_utlb_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_ready;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic [5:0]  lk_perm;
    logic        miss_req;
    logic [19:0] miss_vpn;
    logic [7:0]  miss_asid;
    logic        fill_valid = 1'b0;
    logic        fill_global = 1'b0;
    logic [19:0] fill_pfn = '0;
    logic [5:0]  fill_perm = '0;
    logic        flush = 1'b0;

    int total = 0;
    int fails = 0;

    logic        s_hit, s_rdy;
    logic [19:0] s_pfn;
    logic [5:0]  s_perm;

    always #2 clk = ~clk;

    utlb_cache #(.ENTRIES(8)) i_utlb_cache (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .miss_req(miss_req), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
        .fill_valid(fill_valid), .fill_global(fill_global),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush(flush)
    );

    typedef struct packed {
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic        exp_hit;
        logic        glob;
        logic [19:0] pfn;
        logic [5:0]  perm;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{20'h00010, 8'd5, 1'b0, 1'b0, 20'hA0010, 6'h3F, 4'd5},  // R5 first miss
        '{20'h00010, 8'd5, 1'b1, 1'b0, 20'hA0010, 6'h3F, 4'd2},  // R2
        '{20'h00010, 8'd6, 1'b0, 1'b0, 20'hB0010, 6'h07, 4'd4},  // R4 other id misses
        '{20'h00010, 8'd6, 1'b1, 1'b0, 20'hB0010, 6'h07, 4'd4},  // R4 coexist
        '{20'h00020, 8'd1, 1'b0, 1'b1, 20'hC0020, 6'h38, 4'd5},  // R5 global fill
        '{20'h00020, 8'd9, 1'b1, 1'b1, 20'hC0020, 6'h38, 4'd3},  // R3
        '{20'h00010, 8'd5, 1'b1, 1'b0, 20'hA0010, 6'h3F, 4'd2},  // R2
        '{20'h00011, 8'd5, 1'b0, 1'b0, 20'hD0011, 6'h15, 4'd5},  // R5
        '{20'h00011, 8'd5, 1'b1, 1'b0, 20'hD0011, 6'h15, 4'd2},  // R2
        '{20'h00011, 8'd7, 1'b0, 1'b0, 20'hE0011, 6'h2A, 4'd4}   // R4
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // lookup sampled without letting it reach a clock edge
    task automatic peek(input logic [19:0] vpn, input logic [7:0] asid);
        @(negedge clk);
        lk_vpn = vpn; lk_asid = asid; lk_valid = 1'b1;
        #1;
        s_hit = lk_hit; s_pfn = lk_pfn; s_perm = lk_perm; s_rdy = lk_ready;
        lk_valid = 1'b0;
    endtask

    // lookup held across one clock edge
    task automatic look(input logic [19:0] vpn, input logic [7:0] asid);
        @(negedge clk);
        lk_vpn = vpn; lk_asid = asid; lk_valid = 1'b1;
        #1;
        s_hit = lk_hit; s_pfn = lk_pfn; s_perm = lk_perm; s_rdy = lk_ready;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic respond(input logic g, input logic [19:0] pfn,
                           input logic [5:0] perm, input logic with_flush);
        @(negedge clk);
        fill_valid = 1'b1; fill_global = g; fill_pfn = pfn; fill_perm = perm;
        flush = with_flush;
        @(posedge clk);
        #1 fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    task automatic miss_and_fill(input logic [19:0] vpn, input logic [7:0] asid,
                                 input logic [19:0] pfn);
        look(vpn, asid);
        respond(1'b0, pfn, 6'h01, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1", "ready", lk_ready, 1);
        chk("R1", "miss_req", miss_req, 0);
        peek(20'h00010, 8'd5);
        chk("R1", "hit", s_hit, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            look(VECS[i].vpn, VECS[i].asid);
            chk(tag, "hit", s_hit, VECS[i].exp_hit);
            if (VECS[i].exp_hit) begin
                chk(tag, "pfn", s_pfn, VECS[i].pfn);
                chk(tag, "perm", s_perm, VECS[i].perm);
            end else begin
                chk(tag, "miss_req", miss_req, 1);
                chk(tag, "miss_vpn", miss_vpn, VECS[i].vpn);
                chk(tag, "miss_asid", miss_asid, VECS[i].asid);
                respond(VECS[i].glob, VECS[i].pfn, VECS[i].perm, 1'b0);
                chk("R7", "miss_req after fill", miss_req, 0);
                peek(VECS[i].vpn, VECS[i].asid);
                chk("R7", "hit after fill", s_hit, 1);
                chk("R7", "pfn after fill", s_pfn, VECS[i].pfn);
                chk("R7", "perm after fill", s_perm, VECS[i].perm);
            end
        end

        // R6 stall and R5 hold
        look(20'h00777, 8'd5);
        chk("R5", "miss on new page", s_hit, 0);
        peek(20'h00010, 8'd5);
        chk("R6", "ready while pending", s_rdy, 0);
        chk("R6", "hit while pending", s_hit, 0);
        repeat (3) @(posedge clk);
        #1;
        chk("R5", "req held", miss_req, 1);
        chk("R5", "vpn held", miss_vpn, 20'h00777);
        respond(1'b0, 20'h77777, 6'h01, 1'b0);
        peek(20'h00777, 8'd5);
        chk("R7", "stalled page installed", s_pfn, 20'h77777);

        // R10 flush
        pulse_flush();
        peek(20'h00010, 8'd5);
        chk("R10", "hit after flush", s_hit, 0);
        peek(20'h00020, 8'd9);
        chk("R10", "global hit after flush", s_hit, 0);

        // R8 fill every slot, R9 replacement
        for (int k = 0; k < 8; k++) begin
            miss_and_fill(20'h00100 + 20'(k), 8'd1, 20'h10000 + 20'(k));
        end
        for (int k = 0; k < 8; k++) begin
            peek(20'h00100 + 20'(k), 8'd1);
            chk("R8", "all slots hit", s_hit, 1);
        end
        look(20'h00100, 8'd1);
        chk("R9", "touch hit", s_hit, 1);
        miss_and_fill(20'h00200, 8'd1, 20'h20000);
        peek(20'h00101, 8'd1);
        chk("R9", "oldest replaced", s_hit, 0);
        peek(20'h00100, 8'd1);
        chk("R9", "touched kept", s_hit, 1);
        for (int k = 2; k < 8; k++) begin
            peek(20'h00100 + 20'(k), 8'd1);
            chk("R9", "others kept", s_hit, 1);
        end
        peek(20'h00200, 8'd1);
        chk("R9", "new entry", s_pfn, 20'h20000);

        // R11 flush with fill
        look(20'h00300, 8'd2);
        respond(1'b0, 20'h30000, 6'h01, 1'b1);
        #1;
        chk("R11", "miss cleared", miss_req, 0);
        chk("R11", "ready", lk_ready, 1);
        peek(20'h00300, 8'd2);
        chk("R11", "fill discarded", s_hit, 0);
        peek(20'h00100, 8'd1);
        chk("R11", "flush applied", s_hit, 0);

        // R12 unsolicited fill
        respond(1'b1, 20'h40000, 6'h3F, 1'b0);
        peek(20'h00300, 8'd2);
        chk("R12", "no install", s_hit, 0);
        chk("R12", "ready", s_rdy, 1);

        summary();
        $finish;
    end

endmodule